// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker serves a translation miss on its own. When a miss arrives with a virtual page number and a process identifier, it records them together with the current page-table root pointer. It then reads a first-level entry from memory and, if that entry is valid, a second-level entry. A valid leaf entry comes back as a single-cycle fill carrying the physical frame number and the access rights. The requester is not otherwise involved. An invalid entry at either level ends the walk with a single-cycle fault that reports the level at which the walk stopped.

The 20-bit virtual page number splits into two fields. The upper 10 bits (vpn[19:10]) index the first-level table. The lower 10 bits (vpn[9:0]) index the second-level table. The 12-bit page offset never reaches the walker. A page-table entry is 32 bits wide. Bit 0 is the valid flag, bits 3:1 hold the access rights and bits 31:12 hold a frame number. Only one walk is in flight at a time. The memory port issues a one-cycle read request with no back-pressure and accepts exactly one response, which may arrive after any number of cycles.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: busy_o, mem_req_o, fill_valid_o and fault_o are all low.
- R2: A miss is accepted only while idle. At the accepting edge the walker captures miss_vpn_i, miss_pid_i and root_i. busy_o is high from the cycle after acceptance through the cycle of the fill or fault pulse, and low in the cycle that follows.
- R3: One cycle after acceptance, mem_req_o pulses for one cycle with mem_addr_o equal to the captured root plus 4 times vpn[19:10].
- R4: If bit 0 of the first-level entry is 0, the walker pulses fault_o with fault_level_o = 0 and issues no second read.
- R5: If bit 0 of the first-level entry is 1, one cycle after the response the walker issues a second read whose address is {entry[31:12], vpn[9:0], 2'b00}.
- R6: A second-level entry with bit 0 set produces a one-cycle fill_valid_o. In that cycle fill_pfn_o = entry[31:12], fill_rights_o = entry[3:1], and out_vpn_o and out_pid_o hold the captured request.
- R7: A second-level entry with bit 0 clear produces a one-cycle fault_o with fault_level_o = 1, together with the captured vpn and pid.
- R8: fill_valid_o and fault_o are never high together. Each is high for exactly one cycle per walk, and the walker is idle in the following cycle.
- R9: A miss presented while busy is dropped: the walk in progress finishes unchanged and no further read follows. A change of root_i after acceptance does not affect the current walk.
- R10: mem_rsp_valid_i is ignored outside the two response-wait states, including in the cycle of a request. Any response latency of at least one cycle is handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss request strobe |
| miss_vpn_i | input | 20 | Virtual page number of the miss |
| miss_pid_i | input | PID_W | Process identifier of the miss |
| root_i | input | 32 | Current page-table root pointer |
| mem_req_o | output | 1 | Memory read request, one cycle |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rsp_valid_i | input | 1 | Memory response strobe |
| mem_rsp_data_i | input | 32 | Entry returned by memory |
| busy_o | output | 1 | Walk in progress |
| fill_valid_o | output | 1 | Translation fill pulse |
| fill_pfn_o | output | 20 | Physical frame number for the fill |
| fill_rights_o | output | 3 | Access rights for the fill |
| fault_o | output | 1 | Page fault pulse |
| fault_level_o | output | 1 | Level that faulted: 0 first, 1 second |
| out_vpn_o | output | 20 | Virtual page number of the finished walk |
| out_pid_o | output | PID_W | Process identifier of the finished walk |

## Verification
The assertions check the cycle-level protocol on every cycle. Fill and fault never occur together and each lasts one cycle. Every read request is a single pulse issued right after acceptance or after a valid first-level response. An invalid first-level response leads straight to a first-level fault, and an idle walker with no miss stays idle. Whether addresses are formed correctly, whether the fill fields carry the right bits of the leaf entry, and whether late misses, root changes and stray responses are ignored can only be shown by the bench. It runs whole walks against a modelled memory with random and directed page tables, latencies and interference.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  parameter int VA_W     = 32;
  parameter int OFF_W    = 12;
  parameter int IDX_W    = 10;
  parameter int PTE_W    = 32;
  parameter int RIGHTS_W = 3;
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int PFN_W   = PTE_W - OFF_W;
  localparam int ENT_B   = $clog2(PTE_W / 8);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD1, ST_WT1, ST_RD2, ST_WT2, ST_FILL, ST_FAULT
  } walk_state_e;

  function automatic logic pte_valid(input logic [PTE_W-1:0] pte);
    return pte[0];
  endfunction

  function automatic logic [PFN_W-1:0] pte_frame(input logic [PTE_W-1:0] pte);
    return pte[PTE_W-1:OFF_W];
  endfunction

  function automatic logic [RIGHTS_W-1:0] pte_rights(input logic [PTE_W-1:0] pte);
    return pte[RIGHTS_W:1];
  endfunction
endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr
  import pt_walker_pkg::*;
(
  input  logic [VA_W-1:0]  root_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PFN_W-1:0] l1_frame_i,
  input  logic             sel_l2_i,
  output logic [VA_W-1:0]  addr_o
);
  localparam int P2_W = VPN_W - IDX_W;

  logic [IDX_W-1:0] p1;
  logic [P2_W-1:0]  p2;
  logic [VA_W-1:0]  l1_addr, l2_addr;

  assign p1      = vpn_i[VPN_W-1:P2_W];
  assign p2      = vpn_i[P2_W-1:0];
  assign l1_addr = root_i + VA_W'({p1, {ENT_B{1'b0}}});
  // frame << OFF_W plus scaled index; the index never carries into the frame
  assign l2_addr = {l1_frame_i, p2, {ENT_B{1'b0}}};
  assign addr_o  = sel_l2_i ? l2_addr : l1_addr;
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
#(
  parameter int PID_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                miss_valid_i,
  input  logic [VPN_W-1:0]    miss_vpn_i,
  input  logic [PID_W-1:0]    miss_pid_i,
  input  logic [VA_W-1:0]     root_i,
  input  logic                mem_rsp_valid_i,
  input  logic [PTE_W-1:0]    mem_rsp_data_i,
  output logic                mem_req_o,
  output logic                sel_l2_o,
  output logic [VA_W-1:0]     root_q_o,
  output logic [PFN_W-1:0]    l1_frame_o,
  output logic                busy_o,
  output logic                fill_valid_o,
  output logic [PFN_W-1:0]    fill_pfn_o,
  output logic [RIGHTS_W-1:0] fill_rights_o,
  output logic                fault_o,
  output logic                fault_level_o,
  output logic [VPN_W-1:0]    out_vpn_o,
  output logic [PID_W-1:0]    out_pid_o
);
  walk_state_e      state_q, state_d;
  logic [VPN_W-1:0] vpn_q;
  logic [PID_W-1:0] pid_q;
  logic [VA_W-1:0]  root_q;
  logic [PFN_W-1:0] frame_q;
  logic [PTE_W-1:0] leaf_q;
  logic             level_q;
  logic             rsp_ok;

  assign rsp_ok = mem_rsp_valid_i && pte_valid(mem_rsp_data_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (miss_valid_i) state_d = ST_RD1;
      ST_RD1:   state_d = ST_WT1;
      ST_WT1:   if (mem_rsp_valid_i) state_d = rsp_ok ? ST_RD2 : ST_FAULT;
      ST_RD2:   state_d = ST_WT2;
      ST_WT2:   if (mem_rsp_valid_i) state_d = rsp_ok ? ST_FILL : ST_FAULT;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      pid_q   <= '0;
      root_q  <= '0;
      frame_q <= '0;
      leaf_q  <= '0;
      level_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && miss_valid_i) begin
        vpn_q  <= miss_vpn_i;
        pid_q  <= miss_pid_i;
        root_q <= root_i;
      end
      if (state_q == ST_WT1 && mem_rsp_valid_i) begin
        frame_q <= pte_frame(mem_rsp_data_i);
        level_q <= 1'b0;
      end
      if (state_q == ST_WT2 && mem_rsp_valid_i) begin
        leaf_q  <= mem_rsp_data_i;
        level_q <= 1'b1;
      end
    end
  end

  assign mem_req_o     = (state_q == ST_RD1) || (state_q == ST_RD2);
  assign sel_l2_o      = (state_q == ST_RD2);
  assign root_q_o      = root_q;
  assign l1_frame_o    = frame_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign fill_valid_o  = (state_q == ST_FILL);
  assign fault_o       = (state_q == ST_FAULT);
  assign fault_level_o = level_q;
  assign fill_pfn_o    = pte_frame(leaf_q);
  assign fill_rights_o = pte_rights(leaf_q);
  assign out_vpn_o     = vpn_q;
  assign out_pid_o     = pid_q;

  // R8
  fill_fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_valid_o && fault_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_o || fault_o) |=> !(fill_valid_o || fault_o) && !busy_o);
  // R3
  req_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && miss_valid_i) |=> mem_req_o && !sel_l2_o);
  // R3
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R4
  l1_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WT1 && mem_rsp_valid_i && !mem_rsp_data_i[0])
      |=> fault_o && !fault_level_o && !mem_req_o);
  // R5
  l2_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WT1 && mem_rsp_valid_i && mem_rsp_data_i[0]) |=> mem_req_o && sel_l2_o);
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !miss_valid_i) |=> !busy_o);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int PID_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                miss_valid_i,
  input  logic [VPN_W-1:0]    miss_vpn_i,
  input  logic [PID_W-1:0]    miss_pid_i,
  input  logic [VA_W-1:0]     root_i,
  output logic                mem_req_o,
  output logic [VA_W-1:0]     mem_addr_o,
  input  logic                mem_rsp_valid_i,
  input  logic [PTE_W-1:0]    mem_rsp_data_i,
  output logic                busy_o,
  output logic                fill_valid_o,
  output logic [PFN_W-1:0]    fill_pfn_o,
  output logic [RIGHTS_W-1:0] fill_rights_o,
  output logic                fault_o,
  output logic                fault_level_o,
  output logic [VPN_W-1:0]    out_vpn_o,
  output logic [PID_W-1:0]    out_pid_o
);
  logic             sel_l2;
  logic [VA_W-1:0]  root_q;
  logic [PFN_W-1:0] l1_frame;

  pt_walk_fsm #(.PID_W(PID_W)) u_fsm (
    .clk_i, .rst_ni, .miss_valid_i, .miss_vpn_i, .miss_pid_i, .root_i,
    .mem_rsp_valid_i, .mem_rsp_data_i, .mem_req_o,
    .sel_l2_o(sel_l2), .root_q_o(root_q), .l1_frame_o(l1_frame),
    .busy_o, .fill_valid_o, .fill_pfn_o, .fill_rights_o,
    .fault_o, .fault_level_o, .out_vpn_o, .out_pid_o
  );

  pt_walk_addr u_addr (
    .root_i(root_q), .vpn_i(out_vpn_o), .l1_frame_i(l1_frame),
    .sel_l2_i(sel_l2), .addr_o(mem_addr_o)
  );
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        miss_valid_i = 1'b0;
  logic [19:0] miss_vpn_i = '0;
  logic [7:0]  miss_pid_i = '0;
  logic [31:0] root_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        busy_o, fill_valid_o, fault_o, fault_level_o;
  logic [19:0] fill_pfn_o, out_vpn_o;
  logic [2:0]  fill_rights_o;
  logic [7:0]  out_pid_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [logic [31:0]];

  always #2 clk_i = ~clk_i;

  pt_walker dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] exp_l1_addr(input logic [31:0] root, input logic [19:0] vpn);
    return root + {20'd0, vpn[19:10], 2'b00};
  endfunction

  function automatic logic [31:0] exp_l2_addr(input logic [31:0] l1, input logic [19:0] vpn);
    return {l1[31:12], vpn[9:0], 2'b00};
  endfunction

  // stray: inject a bogus response while the first request is out
  // late: present a second miss and a new root while busy
  task automatic walk(input logic [19:0] vpn, input logic [7:0] pid, input logic [31:0] root,
                      input logic [31:0] l1, input logic [31:0] l2, input int lat,
                      input bit stray, input bit late);
    int nreq = 0, cnt = 0, cyc = 0;
    bit done = 0;
    mem.delete();
    mem[exp_l1_addr(root, vpn)] = l1;
    if (l1[0]) mem[exp_l2_addr(l1, vpn)] = l2;
    @(negedge clk_i);
    miss_valid_i = 1'b1; miss_vpn_i = vpn; miss_pid_i = pid; root_i = root;
    @(negedge clk_i);
    miss_valid_i = 1'b0;
    chk("R2 busy after accept", busy_o, 1);
    if (late) begin
      miss_valid_i = 1'b1; miss_vpn_i = ~vpn; root_i = ~root;
    end
    while (!done && cyc < 200) begin
      mem_rsp_valid_i = 1'b0;
      if (cyc == 2) miss_valid_i = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i = mem_rd(mem_addr_q);
        end
      end
      if (mem_req_o) begin
        nreq++;
        mem_addr_q = mem_addr_o;
        if (nreq == 1) chk("R3 l1 address", mem_addr_o, exp_l1_addr(root, vpn));
        if (nreq == 2) chk("R5 l2 address", mem_addr_o, exp_l2_addr(l1, vpn));
        cnt = lat;
        if (stray && nreq == 1) begin
          mem_rsp_valid_i = 1'b1; mem_rsp_data_i = 32'h0;
        end
      end
      if (fill_valid_o || fault_o) begin
        done = 1;
        chk("R8 exclusive", {fill_valid_o, fault_o} == 2'b11, 0);
        chk("R2 busy in done cycle", busy_o, 1);
        chk("R2 vpn", out_vpn_o, vpn);
        chk("R2 pid", out_pid_o, pid);
        if (!l1[0]) begin
          chk("R4 fault level 0", {fault_o, fault_level_o}, 2'b10);
          chk("R4 single read", nreq, 1);
        end else if (l2[0]) begin
          chk("R6 fill", fill_valid_o, 1);
          chk("R6 pfn", fill_pfn_o, l2[31:12]);
          chk("R6 rights", fill_rights_o, l2[3:1]);
        end else begin
          chk("R7 fault level 1", {fault_o, fault_level_o}, 2'b11);
        end
        if (l1[0]) chk("R5 two reads", nreq, 2);
      end
      if (!done) @(negedge clk_i);
      cyc++;
    end
    if (!done) chk("R10 walk completes", 0, 1);
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0; miss_valid_i = 1'b0;
    chk("R8 single-cycle pulse", {fill_valid_o, fault_o}, 2'b00);
    chk("R2 idle after done", busy_o, 0);
    if (late) begin
      repeat (3) begin
        @(negedge clk_i);
        chk("R9 dropped miss causes no read", {mem_req_o, busy_o}, 2'b00);
      end
    end
  endtask

  logic [31:0] mem_addr_q;

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240613));
    mem_addr_q = '0;
    repeat (2) @(negedge clk_i);
    chk("R1 reset outputs", {busy_o, mem_req_o, fill_valid_o, fault_o}, 4'b0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10: stray response while idle
    mem_rsp_valid_i = 1'b1; mem_rsp_data_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0;
    chk("R10 idle response ignored", {busy_o, mem_req_o, fill_valid_o, fault_o}, 4'b0000);
    // directed corners
    walk(20'hFFFFF, 8'hA5, 32'h8000_0000, 32'h0000_0000, 32'h0, 1, 0, 0);          // R4
    walk(20'h00000, 8'h01, 32'h8000_1000, 32'h1234_5001, 32'hABCD_E00F, 1, 0, 0);  // R6
    walk(20'h3FF00, 8'h02, 32'h8FFF_F000, 32'h0FFF_F001, 32'h5555_500E, 4, 0, 0);  // R7
    walk(20'h12345, 8'h03, 32'h8000_2000, 32'h0000_1001, 32'h0000_1003, 3, 1, 0);  // R10
    walk(20'h54321, 8'h04, 32'h8000_3000, 32'h0765_4001, 32'h3333_300B, 2, 0, 1);  // R9
    // random
    for (int i = 0; i < 60; i++) begin
      logic [31:0] l1, l2, rt;
      rt = {2'b10, 28'($urandom()), 2'b00};
      l1 = {1'b0, 31'($urandom())};
      l2 = $urandom();
      if (($urandom() % 5) == 0) l1[0] = 1'b0; else l1[0] = 1'b1;
      walk(20'($urandom()), 8'($urandom()), rt, l1, l2, 1 + int'($urandom() % 6),
           bit'($urandom() % 4 == 0), bit'($urandom() % 4 == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule